// File: doc/BRIEF.md
# Secondary Bus Clock-Stop Controller

This block decides when a bridge may switch off the clock of its secondary bus and when that clock must come back. It runs on a free-running clock, so it can still see wake events while the gated secondary clock is off. It drives a clock-enable toward an external gating cell. It also drives a keep-clock request toward the central resource of the primary bus.

An 8-bit control register sets the behaviour. It selects one of two stop policies:
- **Stop on request:** the clock stops only when the primary central resource asks for a stop.
- **Stop when idle:** the clock stops whenever the secondary bus is idle and no primary request is pending.

Separate enables gate the primary stop handshake and secondary stopping as a whole. The register's lowest bit reads back whether the secondary clock is currently stopped.

Internally the controller is a two-state machine, running and stopped. A stop takes effect on the clock edge where the selected condition holds. Two wake sources bring the clock back on the next edge: a downstream transaction strobe, and the active-low clock-run input from the secondary side. A wake always wins over a stop that occurs in the same cycle.

Top module: `sec_clkstop_ctrl`

## Requirements
- R1: After reset the control register reads 00h, the clock-enable is 1 and the keep-clock request is 1; bits 7..5 always read 0.
- R2: A write stores bits 4..1 (bit 4 = stop policy, bit 3 = primary stop enable, bit 2 = keep-clock, bit 1 = secondary stop enable); a written bit 0 is ignored and bit 0 always reads the stopped status.
- R3: With bit 4 = 0, the clock stops on the edge where `pri_stop_req` is 1, bit 3 is 1 and bit 1 is 1. A stop request while bit 3 is 0 leaves the clock running.
- R4: With bit 4 = 1 and bit 1 = 1, the clock stops on the edge where `sec_idle` is 1 and `pri_pending` is 0; a pending request or a busy bus keeps it running.
- R5: While bit 1 is 0 the clock never stops. If bit 1 becomes 0 while the clock is stopped, the clock runs again after the next edge.
- R6: A `dn_txn` pulse while stopped sets the clock running again after the next edge.
- R7: `sec_clkrun_n` low while stopped sets the clock running again after the next edge.
- R8: When a wake event and a stop condition are present in the same cycle, the clock stays running.
- R9: `pri_keep_clk` is 1 whenever bit 2 is 1 or the secondary clock is running, and 0 only when bit 2 is 0 and the secondary clock is stopped.
- R10: Read-back bit 0 is 1 exactly when `sec_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write value |
| cfg_rd_data | output | 8 | Control register read-back, bit 0 = stopped status |
| sec_idle | input | 1 | Secondary bus is idle |
| pri_pending | input | 1 | A primary-side request is pending |
| pri_stop_req | input | 1 | Stop request from the primary central resource |
| dn_txn | input | 1 | Downstream transaction strobe (wake) |
| sec_clkrun_n | input | 1 | Secondary clock-run, active low (wake) |
| sec_clk_en | output | 1 | Enable for the secondary clock gate |
| pri_keep_clk | output | 1 | Request to keep the primary clock running |

## Verification
The assertions check the following on every cycle:
- the reserved bits read zero;
- the status bit is the inverse of the clock-enable;
- the keep-clock request is never low while the keep bit is set or the clock runs;
- any wake event, or a cleared secondary enable, leads to a running clock on the next edge;
- a primary stop request with the primary enable cleared never stops the clock.

Only the bench scenarios can show the following:
- each stop policy actually stops the clock on the intended edge;
- a stopped clock stays stopped with no wake event present;
- clearing the enable during a stop takes effect one edge after the write is registered;
- read-back of the register fields matches what was written.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic {SC_RUN = 1'b0, SC_STOP = 1'b1} sc_state_e;

  localparam int BIT_STAT = 0;
  localparam int BIT_SEN  = 1;
  localparam int BIT_KEEP = 2;
  localparam int BIT_PEN  = 3;
  localparam int BIT_MODE = 4;
  localparam int NUM_CTL  = BIT_MODE + 1;

  // selected stop condition for the current cycle
  function automatic logic f_stop_cond(input logic mode_idle, input logic pri_en,
                                       input logic sec_en, input logic idle,
                                       input logic pending, input logic stop_req);
    logic c;
    if (mode_idle) c = idle & ~pending;
    else           c = pri_en & stop_req;
    return sec_en & c;
  endfunction

  function automatic logic f_wake(input logic dn, input logic clkrun_n);
    return dn | ~clkrun_n;
  endfunction
endpackage

// File: rtl/sc_cfg_reg.sv
module sc_cfg_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         stopped,
  output logic [W-1:0] ctrl,
  output logic [W-1:0] rd_data
);
  import sc_pkg::*;
  localparam logic [W-1:0] WMASK = W'((1 << NUM_CTL) - 2);

  logic [W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & WMASK;
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rd_data = ctrl_q & WMASK;
    rd_data[BIT_STAT] = stopped;
  end
endmodule

// File: rtl/sc_fsm.sv
module sc_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_en,
  input  logic              ev_stop,
  input  logic              ev_wake,
  output sc_pkg::sc_state_e state
);
  import sc_pkg::*;
  sc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SC_RUN:  if (ev_stop && !ev_wake) st_d = SC_STOP;
      SC_STOP: if (ev_wake || !sec_en)  st_d = SC_RUN;
      default: st_d = SC_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SC_RUN;
    else        st_q <= st_d;
  end

  assign state = st_q;

  assert_wake_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wake |=> (state == SC_RUN));
  assert_disabled_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |=> (state == SC_RUN));
  assert_stop_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_RUN && ev_stop && !ev_wake) |=> (state == SC_STOP));
  assert_no_spurious_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SC_RUN && !ev_stop) |=> (state == SC_RUN));
endmodule

// File: rtl/sec_clkstop_ctrl.sv
module sec_clkstop_ctrl #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             sec_idle,
  input  logic             pri_pending,
  input  logic             pri_stop_req,
  input  logic             dn_txn,
  input  logic             sec_clkrun_n,
  output logic             sec_clk_en,
  output logic             pri_keep_clk
);
  import sc_pkg::*;

  logic [CFG_W-1:0] ctrl;
  logic             stopped, ev_stop, ev_wake;
  sc_state_e        state;

  sc_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .stopped(stopped), .ctrl(ctrl), .rd_data(cfg_rd_data)
  );

  assign ev_stop = f_stop_cond(ctrl[BIT_MODE], ctrl[BIT_PEN], ctrl[BIT_SEN],
                               sec_idle, pri_pending, pri_stop_req);
  assign ev_wake = f_wake(dn_txn, sec_clkrun_n);

  sc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sec_en(ctrl[BIT_SEN]),
    .ev_stop(ev_stop), .ev_wake(ev_wake), .state(state)
  );

  assign stopped      = (state == SC_STOP);
  assign sec_clk_en   = ~stopped;
  assign pri_keep_clk = ctrl[BIT_KEEP] | ~stopped;

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[CFG_W-1:NUM_CTL] == '0);
  assert_status_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[BIT_STAT] == !sec_clk_en);
  assert_keep_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[BIT_KEEP] || sec_clk_en) |-> pri_keep_clk);
  assert_pri_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd_data[BIT_MODE] && !cfg_rd_data[BIT_PEN] && sec_clk_en) |=> sec_clk_en);
endmodule

// File: tb/sim_sec_clkstop_ctrl.sv
module sim_sec_clkstop_ctrl;
  typedef struct {
    logic       en;
    logic       keep;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  logic       clk = 0, rst_n = 0;
  logic       cfg_wr_en = 0;
  logic [7:0] cfg_wr_data = 0;
  logic [7:0] cfg_rd_data;
  logic       sec_idle = 0, pri_pending = 0, pri_stop_req = 0, dn_txn = 0, sec_clkrun_n = 1;
  logic       sec_clk_en, pri_keep_clk;

  int   n_checks = 0, n_errors = 0;
  exp_t sbq[$];
  logic [7:0] m_ctrl = 0;
  logic       m_stop = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  sec_clkstop_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .sec_idle(sec_idle), .pri_pending(pri_pending),
    .pri_stop_req(pri_stop_req), .dn_txn(dn_txn), .sec_clkrun_n(sec_clkrun_n),
    .sec_clk_en(sec_clk_en), .pri_keep_clk(pri_keep_clk)
  );

  task automatic compare(input exp_t e);
    n_checks++;
    if (sec_clk_en !== e.en || pri_keep_clk !== e.keep || cfg_rd_data !== e.rd) begin
      n_errors++;
      $display("FAIL %s: got en=%b keep=%b rd=%h, expected en=%b keep=%b rd=%h",
               e.tag, sec_clk_en, pri_keep_clk, cfg_rd_data, e.en, e.keep, e.rd);
    end
  endtask

  // monitor: pops one expectation per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) compare(sbq.pop_front());
  end

  // driver: apply inputs for one edge, predict the result, push it
  task automatic step(input bit wr, input logic [7:0] wd, input bit idle, input bit pend,
                      input bit pstop, input bit dn, input bit crn, input string tag);
    bit   want_stop, wake;
    exp_t e;
    cfg_wr_en = wr; cfg_wr_data = wd; sec_idle = idle; pri_pending = pend;
    pri_stop_req = pstop; dn_txn = dn; sec_clkrun_n = crn;
    // prediction from the register value before this edge
    wake = dn || !crn;
    if (!m_ctrl[1])     want_stop = 0;
    else if (m_ctrl[4]) want_stop = idle && !pend;
    else                want_stop = m_ctrl[3] && pstop;
    if (m_stop) m_stop = !(wake || !m_ctrl[1]);
    else        m_stop = want_stop && !wake;
    if (wr) m_ctrl = wd & 8'h1E;
    @(posedge clk);
    #1;
    e.en = !m_stop; e.keep = m_ctrl[2] || !m_stop;
    e.rd = {m_ctrl[7:1], m_stop}; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    #1;
  endtask

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.en = 1; r.keep = 1; r.rd = 8'h00; r.tag = "R1 reset state";
    compare(r);
    rst_n = 1;
    @(negedge clk); #1;
    step(1, 8'hFF, 0,0,0,0,1, "R2 write FF reads 1E, R1 reserved zero");
    step(1, 8'h0A, 0,0,0,0,1, "R2 write 0A");
    step(0, 8'h00, 0,0,1,0,1, "R3 primary stop request stops, R9 keep drops, R10");
    step(0, 8'h00, 0,0,0,0,1, "R3 stays stopped without wake");
    step(0, 8'h00, 0,0,0,1,1, "R6 downstream strobe wakes");
    step(1, 8'h02, 0,0,0,0,1, "R2 write 02 primary enable off");
    step(0, 8'h00, 1,0,1,0,1, "R3 stop request ignored when primary enable off");
    step(1, 8'h12, 0,0,0,0,1, "R2 write 12 idle policy");
    step(0, 8'h00, 1,1,0,0,1, "R4 pending request blocks stop");
    step(0, 8'h00, 0,0,0,0,1, "R4 busy bus blocks stop");
    step(0, 8'h00, 1,0,0,0,1, "R4 idle and no request stops");
    step(0, 8'h00, 0,0,0,0,1, "R4 stopped holds when bus busy");
    step(0, 8'h00, 0,0,0,0,0, "R7 clock-run low wakes");
    step(0, 8'h00, 1,0,0,1,1, "R8 wake beats stop (strobe)");
    step(0, 8'h00, 1,0,0,0,0, "R8 wake beats stop (clock-run)");
    step(0, 8'h00, 1,0,0,0,1, "R4 stop again");
    step(1, 8'h10, 1,0,0,0,1, "R5 enable cleared, registered this edge");
    step(0, 8'h00, 1,0,0,0,1, "R5 stopped clock released after clear");
    step(0, 8'h00, 1,0,0,0,1, "R5 never stops while disabled");
    step(1, 8'h17, 0,0,0,0,1, "R2 bit0 write ignored");
    step(0, 8'h00, 1,0,0,0,1, "R9 keep held while stopped, R10 status");
    step(0, 8'h00, 0,0,0,1,1, "R6 wake with keep set");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule